// File: doc/BRIEF.md
# Prioritised Bus Interrupt Status Encoder

This block watches seven active-low interrupt request lines from a system bus. It synchronises them into the local clock domain and keeps a read-only 16-bit status word for software. The word holds a pending flag and the number of the most urgent active level. Level 7 is the most urgent and level 1 the least.

The block also serves host byte reads in an interrupt-vector window. Each level owns one odd byte offset in the window. A read at that offset starts an interrupt-acknowledge cycle for the level. The cycle goes to a bus cycle engine over a request/ready handshake, and the 8-bit vector that the engine returns is handed back to the host.

The status word is laid out so that its raw value is the window offset of the pending level. Software can add it to the window base and read the vector with no shift.

Host read channel rules (valid/ready):
- The host raises `rd_valid_i` with a stable `rd_addr_i` and keeps both unchanged until it sees `rd_ready_o` high.
- Data and the error flag are valid only in the cycle where `rd_ready_o` is high.
- Back-pressure comes only from the block: it holds `rd_ready_o` low while an acknowledge cycle is in flight.

Acknowledge channel rules:
- `ack_req_o` and `ack_level_o` stay stable until the engine answers with `ack_ready_i`, or until the timeout expires.
- The engine drives `ack_vector_i` in the same cycle as `ack_ready_i`.

Top module: `irq_vec_encoder`

## Requirements
- R1: Status bit 0 is 1 when at least one request line is active (low) after synchronisation, and 0 when none is.
- R2: Status bits 3..1 hold the number of the highest active level, where `irq_n_i[k]` is level k+1 and level 7 wins over all lower levels. The field is 0 when nothing is pending.
- R3: Status bits 15..4 always read 0, and the whole status word is 0 after reset.
- R4: A change on the request lines first shows in the status word on the third rising clock edge after it: two synchroniser stages, then the status register.
- R5: A host read at window offset 2L+1, for L from 1 to 7 (0x03 up to 0x0F), raises `ack_req_o` on the next cycle with `ack_level_o` equal to L.
- R6: When the engine raises `ack_ready_i`, the block raises `rd_ready_o` in the same cycle, passes `ack_vector_i` onto `rd_data_o[7:0]` with `rd_err_o` low, and drops `ack_req_o` on the next cycle.
- R7: A read at an even offset, at offset 0x01, or at any offset of 0x10 or above completes in the same cycle with data 0 and `rd_err_o` low, and raises no acknowledge request.
- R8: While an acknowledge request is outstanding and not answered, `ack_req_o` stays high and `ack_level_o` stays unchanged.
- R9: If no `ack_ready_i` arrives during TIMEOUT_CYC (default 32) cycles of `ack_req_o`, the block completes the read in the last of those cycles with `rd_err_o` high and data 0, and then drops `ack_req_o`.
- R10: When a request is pending, reading the window at an offset equal to the status word value acknowledges the level reported in status bits 3..1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n_i | input | 7 | Active-low bus interrupt requests; bit k is level k+1 |
| status_o | output | 16 | Status word: bit 0 pending, bits 3..1 level, rest 0 |
| rd_valid_i | input | 1 | Host byte read request in the vector window |
| rd_addr_i | input | 8 | Byte offset inside the vector window |
| rd_ready_o | output | 1 | Read completes in this cycle |
| rd_data_o | output | 8 | Returned vector, or 0 |
| rd_err_o | output | 1 | Read ended by acknowledge timeout |
| ack_req_o | output | 1 | Interrupt-acknowledge request to the cycle engine |
| ack_level_o | output | 3 | Level being acknowledged |
| ack_ready_i | input | 1 | Engine finished the acknowledge cycle |
| ack_vector_i | input | 8 | Vector from the engine, valid with ack_ready_i |

## Verification
The assertions rely on the host holding `rd_valid_i` high for as long as an acknowledge request is outstanding. They also rely on the engine answering only while `ack_req_o` is high. The stimulus keeps to both rules: each read task drives `rd_valid_i` until it has sampled `rd_ready_o` high, and it raises `ack_ready_i` only in a cycle where it has seen `ack_req_o` high, after a chosen delay. The request lines change only between reads, on falling edges, and stay stable long enough for the synchronisers to settle before the status word is compared.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } ack_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] irq_n_i,
  output logic [WIDTH-1:0] req_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  // active-low lines are inverted at the first stage; reset means "nothing pending"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= ~irq_n_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign req_o = stg_q[STAGES-1];

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_LEVELS = 7,
  parameter int STAT_W     = 16,
  localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] req_i,
  output logic [STAT_W-1:0]     status_o
);

  logic [LVL_W-1:0]  top_lvl;
  logic [STAT_W-1:0] status_q;

  // later iterations overwrite, so the highest active level wins
  always_comb begin
    top_lvl = '0;
    for (int k = 0; k < NUM_LEVELS; k++) begin
      if (req_i[k]) top_lvl = LVL_W'(k + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= {{(STAT_W-LVL_W-1){1'b0}}, top_lvl, |req_i};
  end

  assign status_o = status_q;

  a_r1_pending_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |=> status_o[0]);

  a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_i) |=> (status_o == '0));

  // R2: no active level above the reported one
  a_r2_no_higher: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |=> (($past(req_i) >> status_o[LVL_W:1]) == '0));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[STAT_W-1:LVL_W+1] == '0);

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NUM_LEVELS  = 7,
  parameter int ADDR_W      = 8,
  parameter int VEC_W       = 8,
  parameter int TIMEOUT_CYC = 32,
  localparam int LVL_W      = $clog2(NUM_LEVELS + 1),
  localparam int CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_ready_o,
  output logic [VEC_W-1:0]  rd_data_o,
  output logic              rd_err_o,
  output logic              ack_req_o,
  output logic [LVL_W-1:0]  ack_level_o,
  input  logic              ack_ready_i,
  input  logic [VEC_W-1:0]  ack_vector_i
);

  ack_state_e       state_q, state_d;
  logic [LVL_W-1:0] lvl_q;
  logic [CNT_W-1:0] wait_q;
  logic [LVL_W-1:0] addr_lvl;
  logic             addr_hit;
  logic             expire;

  // offset 2L+1 selects level L; anything else misses
  assign addr_lvl = rd_addr_i[LVL_W:1];
  assign addr_hit = rd_addr_i[0]
                  && ((rd_addr_i >> (LVL_W + 1)) == '0)
                  && (addr_lvl != '0)
                  && (int'(addr_lvl) <= NUM_LEVELS);
  assign expire   = (wait_q == CNT_W'(TIMEOUT_CYC - 1));

  always_comb begin
    state_d    = state_q;
    rd_ready_o = 1'b0;
    rd_data_o  = '0;
    rd_err_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rd_valid_i) begin
          if (addr_hit) state_d    = ST_ACK;
          else          rd_ready_o = 1'b1;
        end
      end
      ST_ACK: begin
        if (ack_ready_i) begin
          rd_ready_o = 1'b1;
          rd_data_o  = ack_vector_i;
          state_d    = ST_IDLE;
        end else if (expire) begin
          rd_ready_o = 1'b1;
          rd_err_o   = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        wait_q <= '0;
        if (rd_valid_i && addr_hit) lvl_q <= addr_lvl;
      end else begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end

  assign ack_req_o   = (state_q == ST_ACK);
  assign ack_level_o = lvl_q;

  a_r5_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> (ack_level_o != '0));

  a_r6_vector_passed: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_o && ack_ready_i) |-> (rd_ready_o && !rd_err_o && rd_data_o == ack_vector_i));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_o && rd_ready_o) |=> !ack_req_o);

  a_r7_miss_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && rd_ready_o && !ack_req_o) |-> (rd_data_o == '0 && !rd_err_o));

  a_r7_miss_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && rd_ready_o && !ack_req_o) |=> !ack_req_o);

  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_o && !rd_ready_o) |=> (ack_req_o && $stable(ack_level_o)));

  a_r8_host_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> rd_valid_i);

  a_r9_err_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |-> (rd_ready_o && rd_data_o == '0 && !ack_ready_i));

endmodule

// File: rtl/irq_vec_encoder.sv
module irq_vec_encoder #(
  parameter int NUM_LEVELS  = 7,
  parameter int STAT_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 32,
  localparam int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] irq_n_i,
  output logic [STAT_W-1:0]     status_o,
  input  logic                  rd_valid_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic                  rd_ready_o,
  output logic [VEC_W-1:0]      rd_data_o,
  output logic                  rd_err_o,
  output logic                  ack_req_o,
  output logic [LVL_W-1:0]      ack_level_o,
  input  logic                  ack_ready_i,
  input  logic [VEC_W-1:0]      ack_vector_i
);

  logic [NUM_LEVELS-1:0] req_sync;

  irq_sync #(.WIDTH(NUM_LEVELS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_n_i (irq_n_i),
    .req_o   (req_sync)
  );

  irq_prio_enc #(.NUM_LEVELS(NUM_LEVELS), .STAT_W(STAT_W)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_sync),
    .status_o (status_o)
  );

  irq_ack_ctrl #(
    .NUM_LEVELS (NUM_LEVELS),
    .ADDR_W     (ADDR_W),
    .VEC_W      (VEC_W),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ack (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_valid_i   (rd_valid_i),
    .rd_addr_i    (rd_addr_i),
    .rd_ready_o   (rd_ready_o),
    .rd_data_o    (rd_data_o),
    .rd_err_o     (rd_err_o),
    .ack_req_o    (ack_req_o),
    .ack_level_o  (ack_level_o),
    .ack_ready_i  (ack_ready_i),
    .ack_vector_i (ack_vector_i)
  );

endmodule

// File: tb/irq_vec_encoder_test.sv
module irq_vec_encoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_n = 7'h7F;
  logic [15:0] status;
  logic       rd_valid = 1'b0;
  logic [7:0] rd_addr = '0;
  logic       rd_ready;
  logic [7:0] rd_data;
  logic       rd_err;
  logic       ack_req;
  logic [2:0] ack_level;
  logic       ack_ready = 1'b0;
  logic [7:0] ack_vector = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_encoder uut (
    .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .status_o(status),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_ready_o(rd_ready),
    .rd_data_o(rd_data), .rd_err_o(rd_err), .ack_req_o(ack_req),
    .ack_level_o(ack_level), .ack_ready_i(ack_ready), .ack_vector_i(ack_vector)
  );

  function automatic logic [15:0] exp_status(input logic [6:0] n);
    logic [2:0] lvl = '0;
    for (int k = 0; k < 7; k++) if (!n[k]) lvl = 3'(k + 1);
    return {12'b0, lvl, (lvl != 0)};
  endfunction

  function automatic int exp_level(input logic [7:0] a);
    if (a[0] && a[7:4] == 0 && a[3:1] != 0) return int'(a[3:1]);
    return 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_irq(input logic [6:0] n);
    @(negedge clk);
    irq_n = n;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // one host read; engine answers after 'delay' cycles of ack_req (never if delay >= TMO)
  task automatic do_read(input logic [7:0] a, input int delay, input logic [7:0] vec,
                         output logic [7:0] d, output logic e, output int lvl,
                         output int ack_cyc, output int wait_cyc);
    bit done = 0;
    lvl = 0; ack_cyc = 0; wait_cyc = 0; d = '0; e = 1'b0;
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; ack_ready = 1'b0;
    while (!done && wait_cyc < 500) begin
      #1;
      if (ack_req) begin
        lvl = int'(ack_level);
        if (ack_cyc == delay) begin
          ack_ready = 1'b1; ack_vector = vec; #1;
        end
        ack_cyc++;
      end
      if (rd_ready) begin
        d = rd_data; e = rd_err; done = 1;
      end
      @(negedge clk);
      if (!done) wait_cyc++;
    end
    rd_valid = 1'b0; ack_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d; logic e; int lvl, ac, wc;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R3 reset status", status, 16'h0);
    check("R5 reset no ack", ack_req, 0);
    rst_n = 1'b1;

    // R4 latency: visible on third edge, not second
    @(negedge clk); irq_n = 7'b1111110;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R4 not yet after two edges", status, 16'h0);
    @(posedge clk); @(negedge clk);
    check("R4 shown on third edge", status, 16'h0003);

    // directed priority corners
    set_irq(7'b0111111); check("R2 level 7 alone", status, 16'h000F);
    set_irq(7'b0000000); check("R2 all active picks 7", status, 16'h000F);
    set_irq(7'b1111011); check("R1 single level 3", status, 16'h0007);
    set_irq(7'b1111111); check("R1 none pending", status, 16'h0000);

    // random status patterns, R1 R2 R3
    for (int i = 0; i < 40; i++) begin
      logic [6:0] n = 7'($urandom());
      set_irq(n);
      check("R2 random status", status, exp_status(n));
    end

    // each level offset, R5 R6
    for (int l = 1; l <= 7; l++) begin
      logic [7:0] v = 8'($urandom());
      do_read(8'(2*l + 1), l % 4, v, d, e, lvl, ac, wc);
      check("R5 ack level", lvl, l);
      check("R6 vector", d, v);
      check("R6 no error", e, 0);
      check("R8 held cycles", ac, (l % 4) + 1);
    end

    // misses, R7
    foreach (d[i]) ;
    begin
      logic [7:0] bad [6] = '{8'h00, 8'h01, 8'h02, 8'h0E, 8'h11, 8'h1F};
      for (int i = 0; i < 6; i++) begin
        do_read(bad[i], 0, 8'hA5, d, e, lvl, ac, wc);
        check("R7 miss data", d, 0);
        check("R7 miss no ack", ac, 0);
        check("R7 miss same cycle", wc, 0);
      end
    end

    // timeout, R9
    do_read(8'h0B, TMO + 5, 8'h55, d, e, lvl, ac, wc);
    check("R9 error flag", e, 1);
    check("R9 data zero", d, 0);
    check("R9 ack cycles", ac, TMO);
    #1; check("R9 ack dropped", ack_req, 0);
    // last-moment answer still succeeds
    do_read(8'h05, TMO - 1, 8'h3C, d, e, lvl, ac, wc);
    check("R9 late answer ok", {e, d}, {1'b0, 8'h3C});

    // random reads and the status-as-offset rule
    for (int i = 0; i < 30; i++) begin
      logic [7:0] a = 8'($urandom()) & 8'h1F;
      logic [7:0] v = 8'($urandom());
      int dl = int'($urandom() % 6);
      do_read(a, dl, v, d, e, lvl, ac, wc);
      check("R5 random level", lvl, exp_level(a));
      check("R6 random data", d, (exp_level(a) != 0) ? v : 8'h00);
    end
    for (int i = 0; i < 10; i++) begin
      logic [6:0] n = 7'($urandom()) & 7'h7E;
      set_irq(n);
      do_read(status[7:0], 1, 8'h42, d, e, lvl, ac, wc);
      check("R10 status offset level", lvl, int'(exp_status(n) >> 1));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule